// File: doc/BRIEF.md
# Huffman Tree Stream Decoder

This block expands a Huffman-coded stream whose code tree is carried inside the stream. A stream starts with one header word that gives the output length and the symbol width. The code tree comes next as a small table of node bytes. The coded bits follow after that. All of these arrive as 32-bit words on a valid/ready input port. The block loads the tree bytes into an internal RAM. It then walks the tree one code bit per clock cycle. Each leaf adds one symbol to a 32-bit accumulator, and every full accumulator leaves on a valid/ready output port.

Each tree node is one byte. The low six bits give the distance to the node's pair of children. The two top bits say whether the left child or the right child is a leaf rather than another node. When the declared number of output bytes has been produced, the block drops any code bits left in the current input word. It then takes the next input word as the header of a new stream.

Input back-pressure: `in_ready` depends only on internal state. A word is taken on every cycle in which `in_valid` and `in_ready` are both high. `in_ready` goes low while the block is still walking the bits of a code word. Output back-pressure: once `out_valid` rises, it stays high with `out_data` unchanged until a cycle in which `out_ready` is high. While a word is waiting, the tree walk stalls.

Top module: `huff_tree_decoder`

## Requirements
- R1: Header word layout. Bits 31:8 are the output byte count and bits 3:0 are the symbol width code. A width code of 0 means 8. The count is rounded up to whole 32-bit words, so a count of 5 yields two output words.
- R2: The word after the header carries the tree size T in bits 7:0. The 2T+1 tree bytes follow in little-endian byte order, with the root at bits 15:8 of that word. Code bits begin at the first word boundary after the last tree byte, and any padding bytes in between are ignored.
- R3: Node byte layout. Bits 5:0 are an offset, bit 6 set means the right child is a leaf, and bit 7 set means the left child is a leaf. The children sit at byte positions P and P+1 with P = (node position with bit 0 cleared) + 2×offset + 2, where positions count from the tree-size byte at 0.
- R4: Code bits are consumed from bit 31 down to bit 0 of each word, and a single code may span two words. A 1 selects the right child and a 0 selects the left child.
- R5: A leaf contributes its low width bits. The first symbol lands at bit 0 of an output word, each later symbol sits just above the previous one, and the walk then restarts at the root.
- R6: A word is emitted as soon as it holds 32 bits. Decoding stops after the last word the count calls for, even in the middle of an input word, and the next input word is treated as a new header.
- R7: A width other than 2, 4 or 8 (code 0 counts as 8) sets `unsupported`. From then until reset, `in_ready` stays low and no output word is produced.
- R8: A word on the output stays valid with stable data until it is accepted. No decoded word is lost or repeated under any pattern of `out_ready`.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `unsupported` is 0.
- R10: A count of zero takes the header and the tree words, produces no output, and leaves the block ready for the next header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Header, tree or code word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Packed symbols, first symbol in the low bits |
| unsupported | output | 1 | Sticky flag for an unsupported symbol width |

## Verification
Each fault inside the block shows up at the ports in a recognisable way:

- A wrong node pointer or a misread leaf flag puts the wrong symbol into the very next output word.
- A wrong bit pointer or a wrong symbol position corrupts the nibble or byte lanes of that same word.
- A count error makes words go missing or extra words appear when a stream ends.
- If the block fails to stop in the middle of a word, the second of two back-to-back streams decodes wrongly, because the leftover code bits are taken for its header.
- A tree-loading or padding error corrupts every symbol of the stream.
- Lost or repeated words under a stalled consumer change the count of accepted words within a few cycles.

// File: rtl/huff_pkg.sv
package huff_pkg;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_TREE,
    ST_WALK,
    ST_BAD
  } hstate_e;

  // Width code 0 stands for an 8-bit symbol.
  function automatic logic [3:0] eff_width(input logic [3:0] code);
    return (code == 4'd0) ? 4'd8 : code;
  endfunction

  // Usable widths are powers of two from 2 to 8: they divide 32 and fit a leaf byte.
  function automatic logic width_ok(input logic [3:0] w);
    return (w > 4'd1) && (w <= 4'd8) && ((w & (w - 4'd1)) == 4'd0);
  endfunction

endpackage

// File: rtl/huff_tree_ram.sv
// Word-written, byte-read tree store with NRD combinational read ports.
module huff_tree_ram #(
  parameter int WAW = 8,
  parameter int NRD = 2,
  localparam int BAW = WAW + 2,
  localparam int DEPTH = 1 << WAW
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [WAW-1:0]           waddr,
  input  logic [31:0]              wdata,
  input  logic [NRD-1:0][BAW-1:0]  raddr,
  output logic [NRD-1:0][7:0]      rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [31:0] rword;
    assign rword    = mem[raddr[p][BAW-1:2]];
    assign rdata[p] = rword[8*raddr[p][1:0] +: 8];
  end

endmodule

// File: rtl/huff_sym_packer.sv
// Collects symbols LSB-first; word_done pulses with the completed word.
module huff_sym_packer #(
  parameter int WORD_W = 32,
  parameter int SYM_W  = 8,
  localparam int POS_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym,
  input  logic [3:0]        width,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data
);

  logic [WORD_W-1:0] acc_q;
  logic [POS_W-1:0]  pos_q;
  logic [SYM_W-1:0]  mask;
  logic [POS_W-1:0]  end_pos;

  assign mask      = SYM_W'((1 << width) - 1);
  assign end_pos   = pos_q + POS_W'(width);
  assign word_data = acc_q | (WORD_W'(sym & mask) << pos_q);
  assign word_done = sym_valid && (end_pos == POS_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      pos_q <= '0;
    end else if (sym_valid) begin
      if (word_done) begin
        acc_q <= '0;
        pos_q <= '0;
      end else begin
        acc_q <= word_data;
        pos_q <= end_pos;
      end
    end
  end

endmodule

// File: rtl/huff_tree_decoder.sv
module huff_tree_decoder #(
  parameter int TREE_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        unsupported
);
  import huff_pkg::*;

  localparam int RAM_WORDS = (TREE_BYTES + 4) / 4;
  localparam int WAW       = $clog2(RAM_WORDS);
  localparam int BAW       = WAW + 2;
  localparam int CNT_W     = 24;
  localparam int REM_W     = CNT_W - 1;
  localparam int TL_W      = $clog2(RAM_WORDS + 1);

  hstate_e          state_q;
  logic [3:0]       width_q;
  logic [REM_W-1:0] rem_q;
  logic [TL_W-1:0]  tleft_q;
  logic [WAW-1:0]   wptr_q;
  logic [BAW-1:0]   node_q;
  logic [31:0]      sh_q;
  logic [5:0]       bits_q;

  logic             in_fire, step_en, stepping;
  logic [7:0]       node_byte, child_byte;
  logic [BAW-1:0]   pair_base, child_addr;
  logic             go_right, hit_leaf, sym_fire;
  logic             word_done;
  logic [31:0]      word_data;
  logic [3:0]       hdr_w;
  logic [REM_W-1:0] rem_hdr;
  logic [TL_W-1:0]  tree_total, eff_left;

  assign in_ready = (state_q == ST_HDR) || (state_q == ST_TREE) ||
                    ((state_q == ST_WALK) && (bits_q == 6'd0));
  assign in_fire  = in_valid && in_ready;
  assign step_en  = !out_valid || out_ready;
  assign stepping = (state_q == ST_WALK) && (bits_q != 6'd0) && step_en;

  // Tree walk: child pair of the current node, then the side picked by the code bit.
  assign pair_base  = {node_q[BAW-1:1], 1'b0} + BAW'({node_byte[5:0], 1'b0}) + BAW'(2);
  assign go_right   = sh_q[31];
  assign child_addr = pair_base + BAW'(go_right);
  assign hit_leaf   = go_right ? node_byte[6] : node_byte[7];
  assign sym_fire   = stepping && hit_leaf;

  assign hdr_w      = eff_width(in_data[3:0]);
  assign rem_hdr    = REM_W'(({1'b0, in_data[31:8]} + 25'd3) >> 2);
  assign tree_total = TL_W'(({2'b00, in_data[7:0], 1'b0} + 11'd5) >> 2);
  assign eff_left   = (wptr_q == '0) ? tree_total : tleft_q;

  assign unsupported = (state_q == ST_BAD);

  huff_tree_ram #(.WAW(WAW), .NRD(2)) i_ram (
    .clk   (clk),
    .we    ((state_q == ST_TREE) && in_fire),
    .waddr (wptr_q),
    .wdata (in_data),
    .raddr ({child_addr, node_q}),
    .rdata ({child_byte, node_byte})
  );

  huff_sym_packer #(.WORD_W(32), .SYM_W(8)) i_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_fire),
    .sym       (child_byte),
    .width     (width_q),
    .word_done (word_done),
    .word_data (word_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_HDR;
      width_q   <= 4'd8;
      rem_q     <= '0;
      tleft_q   <= '0;
      wptr_q    <= '0;
      node_q    <= BAW'(1);
      sh_q      <= '0;
      bits_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (word_done) begin
        out_valid <= 1'b1;
        out_data  <= word_data;
      end
      case (state_q)
        ST_HDR: begin
          if (in_fire) begin
            if (!width_ok(hdr_w)) begin
              state_q <= ST_BAD;
            end else begin
              width_q <= hdr_w;
              rem_q   <= rem_hdr;
              wptr_q  <= '0;
              state_q <= ST_TREE;
            end
          end
        end
        ST_TREE: begin
          if (in_fire) begin
            wptr_q  <= wptr_q + WAW'(1);
            tleft_q <= eff_left - TL_W'(1);
            if (eff_left == TL_W'(1)) begin
              node_q  <= BAW'(1);
              bits_q  <= '0;
              state_q <= (rem_q == '0) ? ST_HDR : ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (in_fire) begin
            sh_q   <= in_data;
            bits_q <= 6'd32;
          end else if (stepping) begin
            sh_q   <= sh_q << 1;
            bits_q <= bits_q - 6'd1;
            node_q <= hit_leaf ? BAW'(1) : child_addr;
            if (word_done) begin
              rem_q <= rem_q - REM_W'(1);
              if (rem_q == REM_W'(1)) begin
                state_q <= ST_HDR;
                bits_q  <= '0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/huff_tree_decoder_chk.sv
module huff_tree_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        unsupported
);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  assert_bad_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |=> unsupported);

  assert_bad_no_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> !in_ready);

  assert_bad_no_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported && !out_valid |=> !out_valid);

endmodule

bind huff_tree_decoder huff_tree_decoder_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .unsupported (unsupported)
);

// File: tb/test_huff_tree_decoder.sv
module test_huff_tree_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        unsupported;

  always #(CLK_PERIOD/2) clk = ~clk;

  huff_tree_decoder i_huff_tree_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .unsupported(unsupported)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp = 1'b0;

  logic [31:0] stim [0:63];
  int n_stim;
  logic [31:0] expw [0:63];
  int n_exp;
  logic [31:0] got [0:255];
  int n_got = 0;
  bit bitbuf [0:2047];

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Output monitor and consumer: decides out_ready and records handshakes between edges.
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      errors++;
      summary();
      $finish;
    end
    out_ready = bp ? (cyc % 3 == 0) : 1'b1;
    if (rst_n && out_valid && out_ready && n_got < 256) begin
      got[n_got] = out_data;
      n_got++;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Tree tables: node and leaf bytes, and the code of each symbol.
  task automatic tree_words(int tree);
    if (tree == 1) begin
      stim[n_stim++] = 32'h4241C001;
    end else if (tree == 2) begin
      stim[n_stim++] = 32'hFFFF8103;
      stim[n_stim++] = 32'h3EA9C0A5;
    end else begin
      stim[n_stim++] = 32'h07C04002;
      stim[n_stim++] = 32'hDEADF21B;
    end
  endtask

  function automatic int tree_nsym(int tree);
    return (tree == 1) ? 2 : 3;
  endfunction

  task automatic sym_info(int tree, int idx, output logic [7:0] val,
                          output int code, output int len);
    if (tree == 1) begin
      val = (idx == 0) ? 8'h41 : 8'h42; code = idx; len = 1;
    end else if (tree == 2) begin
      if (idx == 0) begin val = 8'hA5; code = 0; len = 1; end
      else if (idx == 1) begin val = 8'hA9; code = 2; len = 2; end
      else begin val = 8'h3E; code = 3; len = 2; end
    end else begin
      if (idx == 0) begin val = 8'h07; code = 1; len = 1; end
      else if (idx == 1) begin val = 8'h1B; code = 0; len = 2; end
      else begin val = 8'hF2; code = 1; len = 2; end
    end
  endtask

  task automatic add_stream(int count, int wcode, int tree, int seed);
    int w;
    int nsym;
    int nbits;
    int pos;
    logic [31:0] acc;
    logic [31:0] cnt;
    w = (wcode == 0) ? 8 : wcode;
    nsym = ((count + 3) / 4) * 32 / w;
    cnt = count;
    stim[n_stim++] = {cnt[23:0], 4'h0, 4'(wcode)};
    tree_words(tree);
    nbits = 0; pos = 0; acc = '0;
    for (int i = 0; i < nsym; i++) begin
      logic [7:0] val;
      int code;
      int len;
      sym_info(tree, (i * i + seed * i + seed) % tree_nsym(tree), val, code, len);
      for (int b = len - 1; b >= 0; b--) begin
        bitbuf[nbits] = code[b];
        nbits++;
      end
      acc = acc | (32'(val & 8'((1 << w) - 1)) << pos);
      pos += w;
      if (pos == 32) begin
        expw[n_exp++] = acc;
        acc = '0;
        pos = 0;
      end
    end
    for (int k = 0; k < (nbits + 31) / 32; k++) begin
      logic [31:0] word;
      word = '0;
      for (int b = 0; b < 32; b++)
        if (32 * k + b < nbits) word[31 - b] = bitbuf[32 * k + b];
      stim[n_stim++] = word;
    end
  endtask

  task automatic send(logic [31:0] w);
    bit taken;
    in_valid = 1'b1;
    in_data = w;
    forever begin
      taken = in_ready;
      @(negedge clk);
      if (taken) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic run(string req);
    int base;
    base = n_got;
    for (int i = 0; i < n_stim; i++) send(stim[i]);
    for (int k = 0; k < 5000 && (n_got - base) < n_exp; k++) @(negedge clk);
    repeat (40) @(negedge clk);
    check((n_got - base) == n_exp, {req, " word count"}, 32'(n_got - base), 32'(n_exp));
    for (int i = 0; i < n_exp; i++)
      check(got[base + i] == expw[i], {req, " word data"}, got[base + i], expw[i]);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(in_ready == 1'b1, "R9 in_ready", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 32'd0);
    check(unsupported == 1'b0, "R9 unsupported", 32'(unsupported), 32'd0);
  endtask

  task automatic t_width8();
    n_stim = 0; n_exp = 0;
    add_stream(8, 8, 1, 1);
    run("R5 width8");
  endtask

  task automatic t_width4_deep();
    n_stim = 0; n_exp = 0;
    add_stream(8, 4, 2, 3);
    run("R3 width4 offset tree");
  endtask

  task automatic t_width0_count5();
    n_stim = 0; n_exp = 0;
    add_stream(5, 0, 1, 2);
    run("R1 width0 count5");
  endtask

  task automatic t_width2_span();
    n_stim = 0; n_exp = 0;
    add_stream(12, 2, 3, 5);
    run("R4 width2 multiword");
  endtask

  task automatic t_padded_tree();
    n_stim = 0; n_exp = 0;
    add_stream(8, 4, 3, 7);
    run("R2 padded tree");
  endtask

  task automatic t_back_to_back();
    n_stim = 0; n_exp = 0;
    add_stream(4, 8, 1, 4);
    add_stream(8, 4, 2, 6);
    add_stream(4, 8, 3, 1);
    run("R6 back to back");
  endtask

  task automatic t_backpressure();
    n_stim = 0; n_exp = 0;
    bp = 1'b1;
    add_stream(16, 4, 3, 2);
    add_stream(12, 8, 2, 9);
    run("R8 backpressure");
    bp = 1'b0;
  endtask

  task automatic t_zero_count();
    n_stim = 0; n_exp = 0;
    add_stream(0, 8, 2, 0);
    add_stream(4, 8, 1, 3);
    run("R10 zero count");
  endtask

  task automatic t_bad_width(int wcode);
    int base;
    do_reset();
    base = n_got;
    send({24'd8, 4'h0, 4'(wcode)});
    check(unsupported == 1'b1, "R7 flag", 32'(unsupported), 32'd1);
    check(in_ready == 1'b0, "R7 in_ready low", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    in_data = 32'h4241C001;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    check(unsupported == 1'b1, "R7 flag held", 32'(unsupported), 32'd1);
    check(n_got == base, "R7 no output", 32'(n_got - base), 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_width8();
    t_width4_deep();
    t_width0_count5();
    t_width2_span();
    t_padded_tree();
    t_back_to_back();
    t_backpressure();
    t_zero_count();
    t_bad_width(1);
    t_bad_width(6);
    t_reset_state();
    t_width8();
    summary();
    $finish;
  end

endmodule